// File: doc/BRIEF.md
# Six-Stage Pipeline Occupancy Sequencer

This block is a cycle-accurate model of how instructions flow through a six-stage execution pipe. It does not compute results. Each instruction is a token carrying an ID. A token enters the first stage and moves one stage per clock. The fourth stage is the execution stage, and it can be made to take two clocks. Software models and performance studies use the block to watch, on each clock, which stage holds which instruction. They also read the total number of cycles that a batch of instructions costs under each machine organisation.

A two-bit mode input picks one of four organisations:

- 0: a non-overlapped machine, with one instruction in flight at a time.
- 1: a plain pipeline in which every stage takes one clock.
- 2: a pipeline whose single execution unit takes two clocks.
- 3: a pipeline with two execution units that take two clocks each.

In mode 3 consecutive instructions alternate between the two units. A start pulse arms the block and clears the cycle counter. After that, the block accepts IDs from a valid/ID stream and signals each acceptance. It reports where every token sits, raises a retire strobe with the ID as a token leaves the last stage, and flags stalls.

Top module: `pipe6_seq`

## Requirements
- R1: A synchronous reset clears every stage valid, both execution-unit valids, the unit alternation pointer, the cycle counter and the armed state, so the cycle after reset shows no occupancy, no retire and a count of zero.
- R2: No ID is accepted before the first start pulse after reset. Once the block is armed, `take` is high in a cycle exactly when `in_valid` is high and stage 1 can load, and the ID present in that cycle enters stage 1 at the next edge.
- R3: In mode 0 an ID is accepted only while stages 1 to 5 and both units are empty, so the next instruction enters stage 1 in the cycle after the previous one leaves stage 6, and n instructions take 6n counted cycles.
- R4: In mode 1 every stage, including execution, holds a token for one clock, and n back-to-back instructions take 6 + (n - 1) counted cycles.
- R5: In mode 2 the execution unit holds a token for two clocks. While stage 3 holds a token that cannot move on, `stall` is high and stages 1 to 3 keep their contents. n back-to-back instructions take 6 + 2n - 1 counted cycles.
- R6: Stage 5 becomes empty (a bubble) on any cycle that follows an edge at which no execution unit released a token.
- R7: In mode 3 tokens alternate between two execution units, each holding a token for two clocks, and the first token after reset goes to unit 0. Occupancy slot 6 (the second unit) is used only in mode 3. No stall occurs, and n back-to-back instructions take 6 + n counted cycles.
- R8: Tokens leave stage 6 in the order they were accepted. `ret_vld` and `ret_id` show the stage 6 contents, which came from stage 5 one edge earlier.
- R9: The start pulse clears the cycle counter. The counter then increments at every edge after which some stage is occupied, so it counts from 1 at the first token's stage 1 cycle up to the last token's stage 6 cycle, and stays frozen afterwards.
- R10: Occupancy slot i, for i from 0 to 6, has its valid on `occ_vld[i]` and its ID on `occ_id[i*IDW +: IDW]`. Slots 0 to 5 are stages 1 to 6, with slot 3 showing execution unit 0, and slot 6 is execution unit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | Organisation: 0 non-overlapped, 1 unit pipeline, 2 two-clock execute, 3 dual two-clock execute |
| start | input | 1 | Arms the block and clears the cycle counter |
| in_valid | input | 1 | An instruction ID is available |
| in_id | input | IDW | ID of the available instruction |
| take | output | 1 | The available ID is accepted at the coming edge |
| occ_vld | output | 7 | Per-slot occupancy |
| occ_id | output | 7*IDW | Per-slot IDs |
| ret_vld | output | 1 | A token retires from stage 6 this cycle |
| ret_id | output | IDW | ID of the retiring token |
| stall | output | 1 | Stage 3 is blocked by the execution stage |
| cyc_cnt | output | CW | Occupied-cycle counter since the last start |

## Verification
The bench builds the block with its default parameters: 8-bit IDs and a 16-bit counter. Because the organisation is a port rather than a parameter, that single build reaches all four modes. It also reaches batches long enough to reach the steady-state cost per instruction in each mode. The 16-bit counter holds every batch count without wrapping, and the 8-bit IDs keep each run's tokens distinct, so that retirement order can be checked one token at a time.

// File: rtl/pipe6_seq.sv
module pipe6_seq #(
  parameter int IDW = 8,
  parameter int CW  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic             start,
  input  logic             in_valid,
  input  logic [IDW-1:0]   in_id,
  output logic             take,
  output logic [6:0]       occ_vld,
  output logic [7*IDW-1:0] occ_id,
  output logic             ret_vld,
  output logic [IDW-1:0]   ret_id,
  output logic             stall,
  output logic [CW-1:0]    cyc_cnt
);
  localparam logic [1:0] M_SERIAL = 2'd0;
  localparam logic [1:0] M_DUAL   = 2'd3;

  logic           armed;
  logic           s1v, s2v, s3v, s5v, s6v;
  logic [IDW-1:0] s1i, s2i, s3i, s5i, s6i;
  logic [1:0]     uv, uage, done;
  logic [IDW-1:0] ui [2];
  logic           ptr, tgt, tgt_free, adv4, hold1, hold2, hold3, quiet;

  always_comb begin
    for (int j = 0; j < 2; j++)
      done[j] = uv[j] && (uage[j] || !mode[1]);
  end

  assign tgt      = (mode == M_DUAL) ? ptr : 1'b0;
  assign tgt_free = !uv[tgt] || done[tgt];
  assign adv4     = s3v && tgt_free;
  assign hold3    = s3v && !adv4;
  assign hold2    = s2v && hold3;
  assign hold1    = s1v && hold2;
  assign quiet    = !(s1v || s2v || s3v || uv[0] || uv[1] || s5v);
  assign take     = armed && in_valid && ((mode == M_SERIAL) ? quiet : !hold1);
  assign stall    = hold3;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed   <= 1'b0;
      s1v     <= 1'b0;
      s2v     <= 1'b0;
      s3v     <= 1'b0;
      s5v     <= 1'b0;
      s6v     <= 1'b0;
      uv      <= '0;
      uage    <= '0;
      ptr     <= 1'b0;
      cyc_cnt <= '0;
    end else begin
      if (start) armed <= 1'b1;
      if (!hold1) begin
        s1v <= take;
        s1i <= in_id;
      end
      if (!hold2) begin
        s2v <= s1v;
        s2i <= s1i;
      end
      if (!hold3) begin
        s3v <= s2v;
        s3i <= s2i;
      end
      for (int j = 0; j < 2; j++) begin
        if (adv4 && (tgt == j[0])) begin
          uv[j]   <= 1'b1;
          uage[j] <= 1'b0;
          ui[j]   <= s3i;
        end else if (done[j]) begin
          uv[j] <= 1'b0;
        end else if (uv[j]) begin
          uage[j] <= 1'b1;
        end
      end
      if (adv4 && mode == M_DUAL) ptr <= !ptr;
      s5v <= |done;
      s5i <= done[1] ? ui[1] : ui[0];
      s6v <= s5v;
      s6i <= s5i;
      if (start) cyc_cnt <= '0;
      else if (take || !quiet) cyc_cnt <= cyc_cnt + 1'b1;
    end
  end

  assign occ_vld = {uv[1], s6v, s5v, uv[0], s3v, s2v, s1v};
  assign occ_id  = {ui[1], s6i, s5i, ui[0], s3i, s2i, s1i};
  assign ret_vld = s6v;
  assign ret_id  = s6i;
endmodule

// File: rtl/pipe6_seq_chk.sv
module pipe6_seq_chk #(
  parameter int IDW = 8,
  parameter int CW  = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       mode,
  input logic             start,
  input logic             take,
  input logic [6:0]       occ_vld,
  input logic [7*IDW-1:0] occ_id,
  input logic             ret_vld,
  input logic [IDW-1:0]   ret_id,
  input logic             stall,
  input logic [CW-1:0]    cyc_cnt
);
  a_r1_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (occ_vld == '0 && cyc_cnt == '0 && !ret_vld));

  a_r3_serial_entry: assert property (@(posedge clk) disable iff (rst)
    (take && mode == 2'd0) |-> (occ_vld[4:0] == '0 && !occ_vld[6]));

  a_r5_stall_hold: assert property (@(posedge clk) disable iff (rst)
    stall |=> (occ_vld[2] && $stable(occ_id[3*IDW-1:2*IDW])));

  a_r7_second_unit: assert property (@(posedge clk) disable iff (rst)
    $rose(occ_vld[6]) |-> ($past(mode) == 2'd3));

  a_r8_retire_source: assert property (@(posedge clk) disable iff (rst)
    ret_vld |-> ($past(occ_vld[4]) && ret_id == $past(occ_id[5*IDW-1:4*IDW])));

  a_r9_count_freeze: assert property (@(posedge clk) disable iff (rst)
    (!start && !take && occ_vld[4:0] == '0 && !occ_vld[6]) |=> $stable(cyc_cnt));
endmodule

bind pipe6_seq pipe6_seq_chk #(.IDW(IDW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .mode(mode), .start(start), .take(take),
  .occ_vld(occ_vld), .occ_id(occ_id), .ret_vld(ret_vld), .ret_id(ret_id),
  .stall(stall), .cyc_cnt(cyc_cnt)
);

// File: tb/pipe6_seq_test.sv
module pipe6_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int IDW = 8;
  localparam int CW  = 16;
  localparam int NV  = 8;
  localparam int VM [NV] = '{0, 0, 1, 1, 2, 2, 3, 3};
  localparam int VN [NV] = '{1, 3, 1, 5, 1, 4, 1, 6};

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, in_valid = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [IDW-1:0] in_id = '0;
  logic take, ret_vld, stall;
  logic [6:0] occ_vld;
  logic [7*IDW-1:0] occ_id;
  logic [IDW-1:0] ret_id;
  logic [CW-1:0] cyc_cnt;

  int checks = 0, errors = 0;
  logic [6:0] snap [64];
  logic snap_st [64];

  pipe6_seq #(.IDW(IDW), .CW(CW)) uut (
    .clk(clk), .rst(rst), .mode(mode), .start(start), .in_valid(in_valid),
    .in_id(in_id), .take(take), .occ_vld(occ_vld), .occ_id(occ_id),
    .ret_vld(ret_vld), .ret_id(ret_id), .stall(stall), .cyc_cnt(cyc_cnt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int expect_cycles(int m, int n);
    case (m)
      0: return 6 * n;
      1: return 6 + n - 1;
      2: return 6 + 2 * n - 1;
      default: return 6 + n;
    endcase
  endfunction

  task automatic run(int m, int n, int base);
    int i = 0, r = 0, c = 0;
    bit st = 0, t;
    string tag;
    tag = (m == 0) ? "R3" : (m == 1) ? "R4" : (m == 2) ? "R5" : "R7";
    @(negedge clk); mode = 2'(m); start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    while (r < n && c < 200) begin
      in_valid = (i < n);
      in_id = IDW'(base + i);
      #1 t = take;
      @(posedge clk);
      if (t) i++;
      c++;
      @(negedge clk);
      if (c < 64) begin
        snap[c] = occ_vld;
        snap_st[c] = stall;
      end
      if (stall) st = 1;
      if (ret_vld) begin
        chk("R8 retire order", int'(ret_id), base + r);
        r++;
      end
    end
    in_valid = 1'b0;
    chk("R8 retire count", r, n);
    repeat (3) @(negedge clk);
    chk({tag, " cycle count"}, int'(cyc_cnt), expect_cycles(m, n));
    chk("R5 stall seen", int'(st), int'(m == 2 && n > 1));
    repeat (2) @(negedge clk);
    chk("R9 count frozen", int'(cyc_cnt), expect_cycles(m, n));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    chk("R1 occupancy after reset", int'(occ_vld), 0);
    chk("R1 counter after reset", int'(cyc_cnt), 0);
    chk("R1 retire after reset", int'(ret_vld), 0);
    in_valid = 1'b1; in_id = 8'h55; mode = 2'd1;
    #1 chk("R2 no take before start", int'(take), 0);
    repeat (2) @(negedge clk);
    chk("R2 empty before start", int'(occ_vld), 0);
    in_valid = 1'b0;

    for (int v = 0; v < NV; v++) run(VM[v], VN[v], 16 * v + 1);

    run(2, 2, 200);
    chk("R6 S5 holds first token", int'(snap[6][4]), 1);
    chk("R6 S5 bubble", int'(snap[7][4]), 0);
    chk("R5 stall at cycle 4", int'(snap_st[4]), 1);
    chk("R5 S3 held at cycle 5", int'(snap[5][2]), 1);

    run(0, 2, 210);
    chk("R3 S1 empty while first in flight", int'(snap[4][0]), 0);
    chk("R3 second enters after first leaves", int'(snap[7][0]), 1);

    run(3, 3, 220);
    chk("R7 R10 both units busy", int'({snap[5][6], snap[5][3]}), 3);

    @(negedge clk); mode = 2'd1; start = 1'b1;
    @(negedge clk); start = 1'b0; in_valid = 1'b1; in_id = 8'h77;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk); rst = 1'b0; in_valid = 1'b0;
    chk("R1 mid-run reset occupancy", int'(occ_vld), 0);
    chk("R1 mid-run reset counter", int'(cyc_cnt), 0);

    run(3, 2, 240);
    chk("R7 first token to unit 0", int'(snap[4][3]), 1);
    chk("R7 R10 unit 1 idle at cycle 4", int'(snap[4][6]), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule